// File: doc/BRIEF.md
# Dual Reference Clock Switchover Controller

This block decides which of two reference inputs, REF1 or REF2, feeds a downstream PLL. It holds one 8-bit control word, written through a simple write strobe and read back unchanged. In manual operation the choice comes from a control bit or from an external select pin. In automatic operation the block watches a per-reference "good" status input. It leaves REF1 when REF1 goes bad and REF2 is good. It can then either return to REF1 once REF1 recovers, or stay on REF2 for good.

Every change of selection passes through a deglitch stage. A requested change takes effect only after the request has stayed unchanged for a programmable number of cycles. A control bit bypasses this stage. The block also drives the two reference power enables and pulses an output for one cycle whenever the selection changes. Automatic operation forces both power enables on. It is suppressed in differential mode, where only the REF1 path carries the reference.

Top module: `refsw_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control word reads 0x00, the selection is REF1 (`sel_ref` = 0), the switch pulse is 0 and both power enables are 0.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored and appears on `cfg_rdata` after that edge. The bit fields are: bit0 automatic mode, bit1 manual source (1 = pin), bit2 manual register pick (0 = REF1, 1 = REF2), bit3 stay on REF2, bit4 deglitch bypass, bit5 differential mode, bit6 REF1 power enable, bit7 REF2 power enable.
- R3: In manual mode (bit0 = 0) the requested reference is bit2 when bit1 = 0, and the level of `ext_sel` when bit1 = 1 (0 = REF1, 1 = REF2).
- R4: In automatic mode with bit3 = 0, the block moves from REF1 to REF2 when REF1 is bad and REF2 is good. It returns to REF1 once REF1 is good again.
- R5: In automatic mode with bit3 = 1, the block stays on REF2 after a switchover, whatever the status inputs do.
- R6: In automatic mode a switch is requested only toward a reference whose status is good. With both references bad, the selection does not change.
- R7: When automatic mode is set and differential mode is clear, both power enables are 1. Otherwise they follow bit6 (REF1) and bit7 (REF2).
- R8: With differential mode set, the requested reference is always REF1. Automatic mode and the manual selection have no effect.
- R9: With the deglitch stage active, the selection changes only after the request has differed from it for DG_CYCLES consecutive clock edges. Shorter excursions are dropped.
- R10: With bit4 = 1, a differing request changes the selection at the first clock edge.
- R11: `switch_pulse` is high for exactly the one cycle that follows each edge at which `sel_ref` changes, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Stored control word |
| ext_sel | input | 1 | External select pin, synchronous to clk (0 = REF1, 1 = REF2) |
| ref1_ok | input | 1 | REF1 status, 1 = good |
| ref2_ok | input | 1 | REF2 status, 1 = good |
| ref1_pwr_en | output | 1 | REF1 input power enable |
| ref2_pwr_en | output | 1 | REF2 input power enable |
| sel_ref | output | 1 | Current selection, 0 = REF1, 1 = REF2 |
| switch_pulse | output | 1 | One-cycle pulse after each selection change |

## Verification
The bench builds the block with the default parameters: DG_CYCLES = 4 and the deglitch stage present. The short window lets the bench place a 2-cycle and a 3-cycle runt next to a request held for exactly four edges. It can therefore tell a dropped excursion from an accepted one at the exact edge. With the stage built in, both the counted path and the runtime bypass path are reachable from one build. The build with the stage left out is not instantiated.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

   localparam int CFG_W = 8;

   // Control word layout, MSB first
   typedef struct packed {
      logic en_b;       // bit7 REF2 power enable
      logic en_a;       // bit6 REF1 power enable
      logic diff_mode;  // bit5 differential reference mode
      logic dg_off;     // bit4 deglitch bypass
      logic hold_b;     // bit3 stay on REF2 after switchover
      logic reg_pick;   // bit2 manual register pick
      logic pin_src;    // bit1 manual source is the pin
      logic auto_mode;  // bit0 automatic switchover
   } refsw_cfg_t;

   localparam logic SEL_REF1 = 1'b0;
   localparam logic SEL_REF2 = 1'b1;

endpackage

// File: rtl/refsw_cfg_reg.sv
module refsw_cfg_reg
   import refsw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [CFG_W-1:0] wdata_i,
   output refsw_cfg_t       cfg_o,
   output logic             pwr_a_o,
   output logic             pwr_b_o
);

   refsw_cfg_t cfg_q;
   logic       force_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we_i) begin
         cfg_q <= refsw_cfg_t'(wdata_i);
      end
   end

   assign force_on = cfg_q.auto_mode && !cfg_q.diff_mode;
   assign pwr_a_o  = force_on || cfg_q.en_a;
   assign pwr_b_o  = force_on || cfg_q.en_b;
   assign cfg_o    = cfg_q;

   // R7: a write of automatic, single-ended mode turns both enables on
   a_r7_power_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(we_i) && $past(wdata_i[0]) && !$past(wdata_i[5]))
      |-> (pwr_a_o && pwr_b_o));

endmodule

// File: rtl/refsw_req.sv
module refsw_req
   import refsw_pkg::*;
(
   input  logic auto_mode_i,
   input  logic diff_mode_i,
   input  logic pin_src_i,
   input  logic reg_pick_i,
   input  logic hold_b_i,
   input  logic ext_sel_i,
   input  logic ref1_ok_i,
   input  logic ref2_ok_i,
   input  logic cur_sel_i,
   output logic req_o
);

   always_comb begin
      if (diff_mode_i) begin
         req_o = SEL_REF1;
      end else if (!auto_mode_i) begin
         req_o = pin_src_i ? ext_sel_i : reg_pick_i;
      end else if (cur_sel_i == SEL_REF1) begin
         // leave REF1 only toward a good REF2
         req_o = (!ref1_ok_i && ref2_ok_i) ? SEL_REF2 : SEL_REF1;
      end else begin
         // revert only when allowed and REF1 is good
         req_o = (!hold_b_i && ref1_ok_i) ? SEL_REF1 : SEL_REF2;
      end
   end

endmodule

// File: rtl/refsw_deglitch.sv
module refsw_deglitch #(
   parameter int DG_CYCLES    = 4,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bypass_i,
   input  logic req_i,
   output logic sel_o,
   output logic pulse_o
);

   localparam int CNT_W = (DG_CYCLES > 1) ? $clog2(DG_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DG_CYCLES - 1);

   logic sel_q;
   logic pulse_q;

   generate
      if (DG_CYCLES < 1) begin : g_bad_cfg
         $error("refsw_deglitch: DG_CYCLES must be at least 1");
      end

      if (HAS_DEGLITCH) begin : g_dg
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q   <= '0;
               sel_q   <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= 1'b0;
               if (req_i == sel_q) begin
                  cnt_q <= '0;
               end else if (bypass_i || (cnt_q == LAST)) begin
                  sel_q   <= req_i;
                  pulse_q <= 1'b1;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         if (DG_CYCLES >= 2) begin : g_hold_chk
            // R9: a counted change follows a request already differing an edge earlier
            a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
               ((sel_q != $past(sel_q)) && !$past(bypass_i))
               |-> ($past(req_i, 2) == sel_q));
         end
      end else begin : g_nodg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q   <= 1'b0;
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= (req_i != sel_q);
               sel_q   <= req_i;
            end
         end
      end
   endgenerate

   assign sel_o   = sel_q;
   assign pulse_o = pulse_q;

   // R11: pulse marks exactly the cycles right after a selection change
   a_r11_pulse_matches_change: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q == (sel_q != $past(sel_q)));

endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
   import refsw_pkg::*;
#(
   parameter int DG_CYCLES    = 4,
   parameter bit HAS_DEGLITCH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   input  logic       ext_sel,
   input  logic       ref1_ok,
   input  logic       ref2_ok,
   output logic       ref1_pwr_en,
   output logic       ref2_pwr_en,
   output logic       sel_ref,
   output logic       switch_pulse
);

   refsw_cfg_t cfg;
   logic       req;
   logic       sel;

   refsw_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata),
      .cfg_o   (cfg),
      .pwr_a_o (ref1_pwr_en),
      .pwr_b_o (ref2_pwr_en)
   );

   refsw_req u_req (
      .auto_mode_i (cfg.auto_mode),
      .diff_mode_i (cfg.diff_mode),
      .pin_src_i   (cfg.pin_src),
      .reg_pick_i  (cfg.reg_pick),
      .hold_b_i    (cfg.hold_b),
      .ext_sel_i   (ext_sel),
      .ref1_ok_i   (ref1_ok),
      .ref2_ok_i   (ref2_ok),
      .cur_sel_i   (sel),
      .req_o       (req)
   );

   refsw_deglitch #(
      .DG_CYCLES    (DG_CYCLES),
      .HAS_DEGLITCH (HAS_DEGLITCH)
   ) u_dg (
      .clk      (clk),
      .rst_n    (rst_n),
      .bypass_i (cfg.dg_off),
      .req_i    (req),
      .sel_o    (sel),
      .pulse_o  (switch_pulse)
   );

   assign sel_ref   = sel;
   assign cfg_rdata = cfg;

   // R6: automatic mode with both references bad leaves the selection alone
   a_r6_both_bad_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.auto_mode && !cfg.diff_mode && !ref1_ok && !ref2_ok)
      |=> $stable(sel_ref));

   // R8: differential mode never moves the selection onto REF2
   a_r8_diff_no_ref2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.diff_mode && !sel_ref) |=> !sel_ref);

endmodule

// File: tb/refsw_ctrl_test.sv
`timescale 1ns/1ps
module refsw_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       ext_sel = 1'b0;
   logic       ref1_ok = 1'b1;
   logic       ref2_ok = 1'b1;
   logic       ref1_pwr_en, ref2_pwr_en, sel_ref, switch_pulse;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   refsw_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_wdata    (cfg_wdata),
      .cfg_rdata    (cfg_rdata),
      .ext_sel      (ext_sel),
      .ref1_ok      (ref1_ok),
      .ref2_ok      (ref2_ok),
      .ref1_pwr_en  (ref1_pwr_en),
      .ref2_pwr_en  (ref2_pwr_en),
      .sel_ref      (sel_ref),
      .switch_pulse (switch_pulse)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ext_sel = 1'b0; ref1_ok = 1'b1; ref2_ok = 1'b1;
      step(2);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rdata", cfg_rdata, 8'h00);
      chk("R1 sel", sel_ref, 1'b0);
      chk("R1 pulse", switch_pulse, 1'b0);
      chk("R1 pwr", {ref2_pwr_en, ref1_pwr_en}, 2'b00);
   endtask

   task automatic t_manual_reg();
      do_reset();
      wr(8'h04);
      chk("R2 readback", cfg_rdata, 8'h04);
      step(3);
      chk("R9 manual reg before window", sel_ref, 1'b0);
      step(1);
      chk("R3 manual reg pick REF2", sel_ref, 1'b1);
      chk("R11 pulse on change", switch_pulse, 1'b1);
      step(1);
      chk("R11 pulse one cycle", switch_pulse, 1'b0);
   endtask

   task automatic t_manual_pin();
      do_reset();
      wr(8'h06);           // pin source, register pick ignored
      step(4);
      chk("R3 pin low selects REF1", sel_ref, 1'b0);
      ext_sel = 1'b1;
      step(4);
      chk("R3 pin high selects REF2", sel_ref, 1'b1);
   endtask

   task automatic t_runt();
      int pulses = 0;
      do_reset();
      wr(8'h02);
      ext_sel = 1'b1;
      step(2);
      ext_sel = 1'b0;
      for (int i = 0; i < 6; i++) begin step(1); pulses += switch_pulse; end
      ext_sel = 1'b1;
      step(3);
      ext_sel = 1'b0;
      for (int i = 0; i < 6; i++) begin step(1); pulses += switch_pulse; end
      chk("R9 runts dropped sel", sel_ref, 1'b0);
      chk("R9 runts dropped pulse", 8'(pulses), 8'd0);
   endtask

   task automatic t_bypass();
      do_reset();
      wr(8'h12);
      ext_sel = 1'b1;
      step(1);
      chk("R10 bypass first edge", sel_ref, 1'b1);
      chk("R11 bypass pulse", switch_pulse, 1'b1);
      step(1);
      chk("R11 bypass pulse ends", switch_pulse, 1'b0);
   endtask

   task automatic t_auto_revert();
      do_reset();
      wr(8'h01);
      chk("R7 auto forces power", {ref2_pwr_en, ref1_pwr_en}, 2'b11);
      ref1_ok = 1'b0;
      step(3);
      chk("R9 auto before window", sel_ref, 1'b0);
      step(1);
      chk("R4 auto to REF2", sel_ref, 1'b1);
      ref1_ok = 1'b1;
      step(4);
      chk("R4 auto revert REF1", sel_ref, 1'b0);
   endtask

   task automatic t_auto_stay();
      do_reset();
      wr(8'h09);
      ref1_ok = 1'b0;
      step(4);
      chk("R5 stay switch to REF2", sel_ref, 1'b1);
      ref1_ok = 1'b1;
      step(10);
      chk("R5 stays after REF1 good", sel_ref, 1'b1);
      ref2_ok = 1'b0;
      step(10);
      chk("R5 stays after REF2 bad", sel_ref, 1'b1);
   endtask

   task automatic t_both_bad();
      do_reset();
      wr(8'h01);
      ref1_ok = 1'b0; ref2_ok = 1'b0;
      step(10);
      chk("R6 both bad hold", sel_ref, 1'b0);
      ref2_ok = 1'b1;
      step(3);
      chk("R6 REF2 good window", sel_ref, 1'b0);
      step(1);
      chk("R6 switch to good REF2", sel_ref, 1'b1);
   endtask

   task automatic t_diff();
      do_reset();
      wr(8'h21);
      chk("R7 diff no force", {ref2_pwr_en, ref1_pwr_en}, 2'b00);
      ref1_ok = 1'b0; ref2_ok = 1'b1;
      step(8);
      chk("R8 diff blocks auto", sel_ref, 1'b0);
      wr(8'h24);
      step(8);
      chk("R8 diff blocks manual", sel_ref, 1'b0);
      wr(8'h04);
      step(4);
      chk("R3 manual after diff clear", sel_ref, 1'b1);
   endtask

   task automatic t_power();
      do_reset();
      wr(8'h40);
      chk("R7 REF1 enable only", {ref2_pwr_en, ref1_pwr_en}, 2'b01);
      wr(8'h80);
      chk("R7 REF2 enable only", {ref2_pwr_en, ref1_pwr_en}, 2'b10);
      wr(8'h81);
      chk("R7 auto overrides", {ref2_pwr_en, ref1_pwr_en}, 2'b11);
      chk("R2 readback 81", cfg_rdata, 8'h81);
   endtask

   initial begin
      t_reset();
      t_manual_reg();
      t_manual_pin();
      t_runt();
      t_bypass();
      t_auto_revert();
      t_auto_stay();
      t_both_bad();
      t_diff();
      t_power();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule